// File: doc/BRIEF.md
# Multi-Mode ADC Channel Scan Sequencer

This block steps a conversion engine through a sequence of input channels and stores each returned sample in a small result buffer. A configuration write loads a 2-bit scan mode, a 2-bit channel field, an input-type flag and a flag that reserves channel 3 for the reference. A later read-start pulse begins a sequence using the loaded settings. The four modes are:

- a range scan from channel 0 up to the selected channel;
- eight conversions of the selected channel;
- a monitor loop that repeats the range scan without end;
- a single conversion of the selected channel.

For each conversion the sequencer sends a one-cycle request with a channel number. It then waits for the engine's done pulse and writes the returned sample at the next buffer position. Samples are stored in the order they were converted, starting at address 0. A host reads them back by address, and a count output tells it how many entries are valid. In differential operation, inputs 0/1 form one pair and inputs 2/3 form the other. The request then names the lower channel of the pair, and a range scan visits pairs rather than single inputs. Any configuration write stops the sequence in progress at once and empties the buffer.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `busy`, `conv_req` and `res_count` are all 0.
- R2: With `cfg_scan` = 2'b00 (range) and `cfg_single_ended` = 1, a sequence converts channels 0, 1, … up to `cfg_chan`, once each in ascending order. `busy` then falls in the same cycle that the last result is counted.
- R3: With `cfg_scan` = 2'b01 (repeat), a sequence converts the selected channel exactly 8 times (REPEAT_N) and then goes idle.
- R4: With `cfg_scan` = 2'b10 (monitor), the range sequence of R2/R8 restarts from its first channel after its last one. `busy` stays 1 until the next configuration write.
- R5: With `cfg_scan` = 2'b11 (once), a sequence makes exactly one conversion of the selected channel and then goes idle.
- R6: The k-th result of a sequence (k from 0) is stored at address k mod DEPTH and is read on `res_data` when `res_addr` = that address. `res_count` equals the number of results stored, saturating at DEPTH.
- R7: With `cfg_ref_excl` = 1, channel 3 is never requested in range or monitor modes; a range reaching 3 ends at 2. In repeat and once modes, channel 3 may still be selected.
- R8: With `cfg_single_ended` = 0, a single-channel mode requests channel {`cfg_chan`[1],0}. A range or monitor scan requests 0 and then 2, stopping after 0 when `cfg_chan`[1] = 0 or `cfg_ref_excl` = 1.
- R9: A sequence starts only on `rd_start` while idle. A `rd_start` while busy has no effect on the requests made or the results stored.
- R10: `cfg_wr` drives `busy` and `res_count` to 0 on the next cycle. It also wins over a `rd_start` in the same cycle, so no request follows.
- R11: `conv_req` is a one-cycle pulse. No new request is issued until the done pulse for the previous one has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load configuration; aborts any sequence |
| cfg_scan | input | 2 | Scan mode: 00 range, 01 repeat, 10 monitor, 11 once |
| cfg_chan | input | 2 | Upper channel (range/monitor) or selected channel |
| cfg_single_ended | input | 1 | 1 single-ended, 0 differential pairs |
| cfg_ref_excl | input | 1 | 1 reserves channel 3 as the reference pin |
| rd_start | input | 1 | Read transaction begins; starts a sequence if idle |
| conv_req | output | 1 | Conversion request pulse |
| conv_ch | output | 2 | Channel for the request |
| conv_done | input | 1 | Conversion finished, sample valid |
| conv_data | input | DW | Sample from the engine |
| busy | output | 1 | Sequence in progress |
| res_count | output | CNT_W | Number of valid buffer entries |
| res_addr | input | AW | Buffer read address |
| res_data | output | DW | Buffer entry at `res_addr` |

## Verification
The assertions assume the engine returns exactly one `conv_done` for each request, and only after that request. The bench's engine stub keeps to this: it holds one pending request, answers after a fixed latency, and never pulses done on its own. A done may still arrive after an abort. Before starting the next sequence, the bench waits well beyond the stub's latency so that such a late pulse lands while the sequencer is idle. Configuration and start pulses are driven away from the clock edge, each lasting a single cycle.

// File: rtl/adc_scan_pkg.sv
// Package: shared types of the scan sequencer.
// Assumes a four-input engine addressed by a 2-bit channel number.
package adc_scan_pkg;
    typedef enum logic [1:0] {
        SCAN_RANGE   = 2'b00,
        SCAN_REPEAT  = 2'b01,
        SCAN_MONITOR = 2'b10,
        SCAN_ONCE    = 2'b11
    } scan_mode_e;

    typedef struct packed {
        scan_mode_e mode;
        logic [1:0] chan;
        logic       single_ended;
        logic       ref_excl;
    } scan_cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'b00,
        SEQ_ISSUE = 2'b01,
        SEQ_WAIT  = 2'b10
    } seq_state_e;
endpackage

// File: rtl/scan_plan.sv
// Module: scan_plan
// Maps the configuration and the current step index to the channel to
// convert, and says whether this step is the last of one pass.
// Purely combinational; assumes the step never passes the pass length.
module scan_plan
    import adc_scan_pkg::*;
#(
    parameter int REPEAT_N = 8,
    parameter int STEP_W   = 3
) (
    input  scan_cfg_t         cfg,
    input  logic [STEP_W-1:0] step,
    output logic [1:0]        ch,
    output logic              last,
    output logic              looping
);
    logic [1:0] range_top;
    logic       pair_top;
    logic [1:0] fixed_ch;

    // Highest single-ended channel of a scan once the reference pin is removed.
    always_comb begin
        range_top = cfg.chan;
        if (cfg.ref_excl && cfg.chan == 2'd3) begin
            range_top = 2'd2;
        end
    end

    // Highest differential pair index of a scan (pair 1 uses channel 3).
    always_comb begin
        pair_top = cfg.chan[1] & ~cfg.ref_excl;
    end

    // Channel used by the single-channel modes.
    always_comb begin
        fixed_ch = cfg.single_ended ? cfg.chan : {cfg.chan[1], 1'b0};
    end

    // Channel and end-of-pass decode for each mode.
    always_comb begin
        looping = (cfg.mode == SCAN_MONITOR);
        unique case (cfg.mode)
            SCAN_REPEAT: begin
                ch   = fixed_ch;
                last = (step == STEP_W'(REPEAT_N - 1));
            end
            SCAN_ONCE: begin
                ch   = fixed_ch;
                last = 1'b1;
            end
            default: begin
                if (cfg.single_ended) begin
                    ch   = step[1:0];
                    last = (step == STEP_W'(range_top));
                end else begin
                    ch   = {step[0], 1'b0};
                    last = (step == STEP_W'(pair_top));
                end
            end
        endcase
    end
endmodule

// File: rtl/seq_ctrl.sv
// Module: seq_ctrl
// Request/wait state machine. Issues one conversion request, waits for
// the done pulse, writes the result and moves to the next step.
// Assumes one done pulse per request, never unsolicited while waiting.
module seq_ctrl
    import adc_scan_pkg::*;
#(
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              last,
    input  logic              looping,
    input  logic              conv_done,
    output logic [STEP_W-1:0] step,
    output logic              conv_req,
    output logic              busy,
    output logic              wr_en,
    output logic              clr
);
    seq_state_e state;

    // Sequence state and step index.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= SEQ_IDLE;
            step  <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_ISSUE;
                        step  <= '0;
                    end
                end
                SEQ_ISSUE: state <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (conv_done) begin
                        if (!last) begin
                            state <= SEQ_ISSUE;
                            step  <= step + 1'b1;
                        end else if (looping) begin
                            state <= SEQ_ISSUE;
                            step  <= '0;
                        end else begin
                            state <= SEQ_IDLE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Moore outputs and buffer controls.
    always_comb begin
        conv_req = (state == SEQ_ISSUE);
        busy     = (state != SEQ_IDLE);
        wr_en    = (state == SEQ_WAIT) && conv_done;
        clr      = abort || (start && state == SEQ_IDLE);
    end

    // R11: a request lasts one cycle.
    p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R11: after a request, the next cycle is spent waiting unless aborted.
    p_wait_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !abort |=> busy && !conv_req);

    // R10: an abort leaves the machine idle.
    p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy);
endmodule

// File: rtl/result_buf.sv
// Module: result_buf
// Result storage written in conversion order at a wrapping pointer,
// read by address. The count saturates at the depth.
// Assumes clear and write are never wanted in the same cycle (clear wins).
module result_buf #(
    parameter int DW    = 10,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic [CNT_W-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;

    // Write pointer and valid count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            count  <= '0;
        end else if (wr_en) begin
            wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (count != CNT_W'(DEPTH)) begin
                count <= count + 1'b1;
            end
        end
    end

    // Storage array, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Read port.
    always_comb begin
        rd_data = mem[rd_addr];
    end

    // R6: the count never exceeds the depth.
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R6: a write without clear never lowers the count.
    p_count_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !clr |=> count != 0);

    // R10: a clear empties the buffer.
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == 0);
endmodule

// File: rtl/adc_scan_seq.sv
// Module: adc_scan_seq (top)
// Holds the configuration, decodes the channel plan, runs the request
// sequence and stores results. Assumes the engine answers each request
// with one done pulse and never sends done without a request.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int DW       = 10,
    parameter int DEPTH    = 8,
    parameter int REPEAT_N = 8,
    parameter int AW       = $clog2(DEPTH),
    parameter int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_scan,
    input  logic [1:0]       cfg_chan,
    input  logic             cfg_single_ended,
    input  logic             cfg_ref_excl,
    input  logic             rd_start,
    output logic             conv_req,
    output logic [1:0]       conv_ch,
    input  logic             conv_done,
    input  logic [DW-1:0]    conv_data,
    output logic             busy,
    output logic [CNT_W-1:0] res_count,
    input  logic [AW-1:0]    res_addr,
    output logic [DW-1:0]    res_data
);
    localparam int STEP_MAX = (REPEAT_N > 4) ? REPEAT_N : 4;
    localparam int STEP_W   = $clog2(STEP_MAX);

    scan_cfg_t         cfg_q;
    logic [STEP_W-1:0] step;
    logic              last;
    logic              looping;
    logic              start;
    logic              wr_en;
    logic              clr;

    // Configuration register, loaded by each configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.mode         <= SCAN_RANGE;
            cfg_q.chan         <= 2'd0;
            cfg_q.single_ended <= 1'b1;
            cfg_q.ref_excl     <= 1'b0;
        end else if (cfg_wr) begin
            cfg_q.mode         <= scan_mode_e'(cfg_scan);
            cfg_q.chan         <= cfg_chan;
            cfg_q.single_ended <= cfg_single_ended;
            cfg_q.ref_excl     <= cfg_ref_excl;
        end
    end

    // A configuration write overrides a read start in the same cycle.
    always_comb begin
        start = rd_start && !cfg_wr;
    end

    scan_plan #(
        .REPEAT_N (REPEAT_N),
        .STEP_W   (STEP_W)
    ) i_plan (
        .cfg     (cfg_q),
        .step    (step),
        .ch      (conv_ch),
        .last    (last),
        .looping (looping)
    );

    seq_ctrl #(
        .STEP_W (STEP_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .abort     (cfg_wr),
        .last      (last),
        .looping   (looping),
        .conv_done (conv_done),
        .step      (step),
        .conv_req  (conv_req),
        .busy      (busy),
        .wr_en     (wr_en),
        .clr       (clr)
    );

    result_buf #(
        .DW    (DW),
        .DEPTH (DEPTH),
        .AW    (AW),
        .CNT_W (CNT_W)
    ) i_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_data (conv_data),
        .rd_addr (res_addr),
        .rd_data (res_data),
        .count   (res_count)
    );

    // R7: the reserved reference channel is skipped in scans.
    p_ref_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && cfg_q.ref_excl && !cfg_q.mode[0] |-> conv_ch != 2'd3);

    // R8: differential requests always name the even channel of a pair.
    p_diff_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !cfg_q.single_ended |-> !conv_ch[0]);

    // R3: repeat mode requests only the selected channel.
    p_repeat_ch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && cfg_q.mode == SCAN_REPEAT && cfg_q.single_ended
        |-> conv_ch == cfg_q.chan);

    // R2: a range scan never goes above the selected channel.
    p_range_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && cfg_q.mode == SCAN_RANGE |-> conv_ch <= cfg_q.chan);

    // R10: a configuration write empties the result count.
    p_cfg_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> res_count == 0 && !busy);
endmodule

// File: tb/test_adc_scan_seq.sv
// Scoreboard bench: tasks push expected channels; a monitor pops and
// compares them on each request; buffer contents are compared with a log
// of the samples returned by the engine stub.
module test_adc_scan_seq;
    localparam int DW    = 10;
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int LAT   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_scan = 2'b00;
    logic [1:0]       cfg_chan = 2'b00;
    logic             cfg_single_ended = 1'b1;
    logic             cfg_ref_excl = 1'b0;
    logic             rd_start = 1'b0;
    logic             conv_req;
    logic [1:0]       conv_ch;
    logic             conv_done = 1'b0;
    logic [DW-1:0]    conv_data = '0;
    logic             busy;
    logic [CNT_W-1:0] res_count;
    logic [AW-1:0]    res_addr = '0;
    logic [DW-1:0]    res_data;

    int total = 0;
    int bad = 0;
    int exp_q[$];
    int pops = 0;
    int data_log[$];
    logic prev_req = 1'b0;
    logic outstanding = 1'b0;

    always #10 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_scan(cfg_scan),
        .cfg_chan(cfg_chan), .cfg_single_ended(cfg_single_ended),
        .cfg_ref_excl(cfg_ref_excl), .rd_start(rd_start),
        .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
        .conv_data(conv_data), .busy(busy), .res_count(res_count),
        .res_addr(res_addr), .res_data(res_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Engine stub: one pending request, fixed latency, sample = {ch, serial}.
    logic       pend = 1'b0;
    int         lat_cnt = 0;
    logic [1:0] stub_ch = 2'd0;
    logic [7:0] serial = 8'd0;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (pend) begin
            if (lat_cnt == 0) begin
                conv_done <= 1'b1;
                conv_data <= {stub_ch, serial};
                data_log.push_back(int'({stub_ch, serial}));
                serial    <= serial + 8'd1;
                pend      <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end else if (conv_req) begin
            pend    <= 1'b1;
            lat_cnt <= LAT;
            stub_ch <= conv_ch;
        end
    end

    // Monitor: compare each request with the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_done) outstanding = 1'b0;
            if (conv_req) begin
                check(!prev_req && !outstanding, "R11", int'(outstanding), 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected request", int'(conv_ch), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    pops++;
                    check(int'(conv_ch) == e, "R2/R3/R5/R7/R8 channel", int'(conv_ch), e);
                end
                outstanding = 1'b1;
            end
            prev_req = conv_req;
        end
    end

    // Expected channels of one pass, derived from the requirements.
    task automatic push_pass(input logic [1:0] m, ch, input logic se, ex);
        if (m == 2'b01) begin
            for (int i = 0; i < 8; i++) exp_q.push_back(se ? int'(ch) : int'(ch & 2'b10));
        end else if (m == 2'b11) begin
            exp_q.push_back(se ? int'(ch) : int'(ch & 2'b10));
        end else if (se) begin
            int top;
            top = (ex && ch == 2'd3) ? 2 : int'(ch);
            for (int c = 0; c <= top; c++) exp_q.push_back(c);
        end else begin
            int topp;
            topp = ex ? 0 : int'(ch[1]);
            for (int k = 0; k <= topp; k++) exp_q.push_back(2 * k);
        end
    endtask

    task automatic cfg_write(input logic [1:0] m, ch, input logic se, ex, input logic with_start);
        @(negedge clk);
        cfg_scan = m; cfg_chan = ch; cfg_single_ended = se; cfg_ref_excl = ex;
        cfg_wr = 1'b1; rd_start = with_start;
        @(negedge clk);
        cfg_wr = 1'b0; rd_start = 1'b0;
    endtask

    task automatic pulse_start();
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
        exp_q.delete();
    endtask

    // Runs a finite sequence and compares count and buffer contents.
    task automatic run_finite(input logic [1:0] m, ch, input logic se, ex,
                              input string req, input bit poke_start);
        int base, n;
        settle();
        base = data_log.size();
        cfg_write(m, ch, se, ex, 1'b0);
        push_pass(m, ch, se, ex);
        n = exp_q.size();
        pulse_start();
        if (poke_start) begin
            repeat (6) @(negedge clk);
            pulse_start();
        end
        while (busy) @(negedge clk);
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        check(int'(res_count) == n, {req, " R6 count"}, int'(res_count), n);
        check(data_log.size() - base == n, {req, " R9 conversions"}, data_log.size() - base, n);
        for (int i = 0; i < n; i++) begin
            res_addr = AW'(i);
            #1;
            check(int'(res_data) == data_log[base + i], "R6 data", int'(res_data), data_log[base + i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !conv_req && res_count == 0, "R1", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && res_count == 0, "R1", int'(res_count), 0);

        run_finite(2'b00, 2'd3, 1'b1, 1'b0, "R2 range 0..3", 1'b0);
        run_finite(2'b00, 2'd1, 1'b1, 1'b0, "R2 range 0..1", 1'b0);
        run_finite(2'b00, 2'd3, 1'b1, 1'b1, "R7 range skip 3", 1'b0);
        run_finite(2'b01, 2'd2, 1'b1, 1'b0, "R3 R9 repeat ch2", 1'b1);
        run_finite(2'b01, 2'd3, 1'b1, 1'b1, "R7 repeat ch3", 1'b0);
        run_finite(2'b11, 2'd1, 1'b1, 1'b0, "R5 once ch1", 1'b0);
        run_finite(2'b00, 2'd3, 1'b0, 1'b0, "R8 diff range", 1'b0);
        run_finite(2'b00, 2'd3, 1'b0, 1'b1, "R8 diff range excl", 1'b0);
        run_finite(2'b01, 2'd3, 1'b0, 1'b0, "R8 diff repeat", 1'b0);

        // R4 monitor loop with buffer wrap (R6).
        begin
            int base;
            settle();
            base = data_log.size();
            cfg_write(2'b10, 2'd2, 1'b1, 1'b0, 1'b0);
            for (int p = 0; p < 5; p++) push_pass(2'b10, 2'd2, 1'b1, 1'b0);
            pops = 0;
            pulse_start();
            while (pops < 10) @(negedge clk);
            check(busy == 1'b1, "R4 busy in monitor", int'(busy), 1);
            check(int'(res_count) == DEPTH, "R6 saturate", int'(res_count), DEPTH);
            res_addr = AW'(0);
            #1;
            check(int'(res_data) == data_log[base + DEPTH], "R6 wrap addr0", int'(res_data), data_log[base + DEPTH]);
            res_addr = AW'(1);
            #1;
            check(int'(res_data) == data_log[base + 1], "R6 addr1", int'(res_data), data_log[base + 1]);
            cfg_write(2'b00, 2'd0, 1'b1, 1'b0, 1'b0);
            exp_q.delete();
            check(!busy && res_count == 0, "R4 R10 stop on cfg", int'(busy), 0);
        end

        // R10 abort mid-sequence with a simultaneous start.
        begin
            settle();
            cfg_write(2'b00, 2'd3, 1'b1, 1'b0, 1'b0);
            push_pass(2'b00, 2'd3, 1'b1, 1'b0);
            pops = 0;
            pulse_start();
            while (pops < 2) @(negedge clk);
            cfg_write(2'b01, 2'd1, 1'b1, 1'b0, 1'b1);
            exp_q.delete();
            check(!busy, "R10 abort busy", int'(busy), 0);
            check(res_count == 0, "R10 abort count", int'(res_count), 0);
            repeat (15) @(negedge clk);
            check(!busy && res_count == 0, "R10 start ignored", int'(res_count), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule